// File: doc/BRIEF.md
# DRAM Bank Timing Scheduler

This block sits between a memory request source and the command bus of a DDR3-class DRAM with eight banks. It takes one request at a time (activate, read, write, precharge, refresh or no-op, each with a bank number and an address word) and issues it on a registered command bus only when every per-bank spacing rule is met. It keeps the open or closed state of each bank, so it can refuse requests that make no sense for that state. A refused request is consumed and flagged, and nothing goes out on the bus for it.

An internal interval timer raises a refresh demand after a set number of cycles since the last refresh. The limit is halved when the high-temperature input is set. While the demand is up, the block accepts no requests. It closes any open banks itself, lowest index first, and then issues the refresh. All spacing values are parameters in clock cycles. The defaults match an 800 MHz command clock: row-to-column 11, precharge period 11, row cycle 39.

Top module: `dram_bank_sched`

## Requirements
- R1: A request accepted in cycle t and not refused appears on the command bus in cycle t+1. It carries the same opcode, bank and address. Opcodes are 0 no-op, 1 activate, 2 read, 3 write, 4 precharge, 5 refresh. An activate opens its bank and a precharge closes it.
- R2: A read or write to a bank is issued no fewer than T_RCD cycles after that bank's activate. The block reaches this minimum when the request is already waiting.
- R3: An activate to a bank is issued no fewer than T_RP cycles after that bank closes and no fewer than T_RC cycles after that bank's previous activate.
- R4: A precharge to a bank is issued no fewer than T_RAS cycles after its activate. It also waits at least the burst length after that bank's last read or write: 4 cycles, or 2 cycles when address bit 12 (burst chop) was set.
- R5: A read or write with address bit 10 set closes its bank at issue. A later column request to that bank is refused. The next activate waits the burst length plus T_RP after the column command.
- R6: These requests are accepted, issue nothing, and raise req_err for one cycle, one cycle after acceptance: an activate to an open bank, a read or write to a closed bank, a refresh while any bank is open, and opcodes 6 or 7.
- R7: refresh_due is high once the cycles elapsed since the last refresh reach T_REFI, or T_REFI_HOT while temp_hot is 1. Reset counts as a refresh.
- R8: While refresh_due is high, req_ready is low. The block precharges open banks, lowest index first. It issues a refresh once all banks are closed and their spacing has elapsed, within T_RC + T_RP + 4 cycles of refresh_due rising.
- R9: After a refresh, no activate or refresh is issued to any bank for T_RFC cycles. A refresh request while all banks are closed is issued and restarts the interval.
- R10: During and just after reset, cmd_valid, req_err and refresh_due are low.
- R11: A no-op request is accepted with no command and no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| temp_hot | input | 1 | Selects the shorter refresh interval |
| req_valid | input | 1 | Request present |
| req_op | input | 3 | Request opcode |
| req_bank | input | BA_W | Request bank |
| req_addr | input | ROW_W | Row for activate; column, bit 10 auto-close, bit 12 chop for read/write |
| req_ready | output | 1 | Request accepted at this edge |
| req_err | output | 1 | Previous accepted request was refused |
| refresh_due | output | 1 | Refresh interval has expired |
| cmd_valid | output | 1 | Command on the bus this cycle |
| cmd_op | output | 3 | Command opcode |
| cmd_bank | output | BA_W | Command bank |
| cmd_addr | output | ROW_W | Command address |

## Verification
The assertions assume a requester holds opcode, bank and address steady from raising req_valid until req_ready is seen. They also assume temp_hot may change at any cycle boundary. The bench drives requests only at falling edges and keeps each one in place until it is taken. Opcodes are drawn with weights from the bench's own view of which banks are open, so most requests are legal, a steady share is deliberately refused, and refreshes meet banks in every state.

// File: rtl/dbs_pkg.sv
package dbs_pkg;

  localparam logic [2:0] OP_NOP = 3'd0;
  localparam logic [2:0] OP_ACT = 3'd1;
  localparam logic [2:0] OP_RD  = 3'd2;
  localparam logic [2:0] OP_WR  = 3'd3;
  localparam logic [2:0] OP_PRE = 3'd4;
  localparam logic [2:0] OP_REF = 3'd5;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dbs_pick.sv
module dbs_pick #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic [N-1:0]  req,
  output logic          found,
  output logic [IW-1:0] idx
);

  // lowest index wins
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end

endmodule

// File: rtl/dbs_refi.sv
module dbs_refi #(
  parameter int T_REFI     = 6240,
  parameter int T_REFI_HOT = 3120
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hot,
  input  logic clr,
  output logic due
);

  localparam int RW = $clog2(T_REFI + 1);
  localparam logic [RW-1:0] SAT     = RW'(T_REFI);
  localparam logic [RW-1:0] LIM_N   = RW'(T_REFI - 1);
  localparam logic [RW-1:0] LIM_HOT = RW'(T_REFI_HOT - 1);

  logic [RW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = clr || (cnt_q != SAT);
    cnt_d  = clr ? '0 : cnt_q + RW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign due = cnt_q >= (hot ? LIM_HOT : LIM_N);

  assert_due_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !due);

  assert_due_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (due && !clr && !hot) |=> due);

endmodule

// File: rtl/dbs_bank.sv
module dbs_bank #(
  parameter int CW    = 8,
  parameter int T_RCD = 11,
  parameter int T_RP  = 11,
  parameter int T_RC  = 39,
  parameter int T_RAS = 28,
  parameter int T_RFC = 208,
  parameter int T_BL8 = 4,
  parameter int T_BL4 = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic do_act,
  input  logic do_col,
  input  logic col_ap,
  input  logic col_bc,
  input  logic do_pre,
  input  logic do_ref,
  output logic is_open,
  output logic act_ok,
  output logic col_ok,
  output logic pre_ok
);

  localparam logic [CW-1:0] L_RCD = CW'(T_RCD - 1);
  localparam logic [CW-1:0] L_RP  = CW'(T_RP - 1);
  localparam logic [CW-1:0] L_RC  = CW'(T_RC - 1);
  localparam logic [CW-1:0] L_RAS = CW'(T_RAS - 1);
  localparam logic [CW-1:0] L_RFC = CW'(T_RFC - 1);
  localparam logic [CW-1:0] L_B8  = CW'(T_BL8 - 1);
  localparam logic [CW-1:0] L_B4  = CW'(T_BL4 - 1);
  localparam logic [CW-1:0] L_A8  = CW'(T_BL8 + T_RP - 1);
  localparam logic [CW-1:0] L_A4  = CW'(T_BL4 + T_RP - 1);

  logic          open_q, open_d;
  logic [CW-1:0] rcd_q, rcd_d, act_q, act_d, pre_q, pre_d;
  logic          upd;

  function automatic logic [CW-1:0] mx(input logic [CW-1:0] a, input logic [CW-1:0] b);
    return (a > b) ? a : b;
  endfunction

  always_comb begin
    open_d = open_q;
    rcd_d  = (rcd_q != '0) ? rcd_q - CW'(1) : rcd_q;
    act_d  = (act_q != '0) ? act_q - CW'(1) : act_q;
    pre_d  = (pre_q != '0) ? pre_q - CW'(1) : pre_q;
    if (do_act) begin
      open_d = 1'b1;
      rcd_d  = L_RCD;
      act_d  = mx(act_d, L_RC);
      pre_d  = mx(pre_d, L_RAS);
    end
    if (do_col) begin
      pre_d = mx(pre_d, col_bc ? L_B4 : L_B8);
      if (col_ap) begin
        open_d = 1'b0;
        act_d  = mx(act_d, col_bc ? L_A4 : L_A8);
      end
    end
    if (do_pre && open_q) begin
      open_d = 1'b0;
      act_d  = mx(act_d, L_RP);
    end
    if (do_ref) begin
      act_d = mx(act_d, L_RFC);
    end
  end

  assign upd = do_act || do_col || do_pre || do_ref ||
               (rcd_q != '0) || (act_q != '0) || (pre_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      rcd_q  <= '0;
      act_q  <= '0;
      pre_q  <= '0;
    end else if (upd) begin
      open_q <= open_d;
      rcd_q  <= rcd_d;
      act_q  <= act_d;
      pre_q  <= pre_d;
    end
  end

  assign is_open = open_q;
  assign act_ok  = (act_q == '0);
  assign col_ok  = (rcd_q == '0);
  assign pre_ok  = (pre_q == '0);

  assert_act_closed_R6: assert property (@(posedge clk) disable iff (!rst_n)
    do_act |-> !open_q);

  assert_act_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
    do_act |-> (act_q == '0));

  assert_col_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
    do_col |-> (open_q && rcd_q == '0));

  assert_pre_spacing_R4: assert property (@(posedge clk) disable iff (!rst_n)
    do_pre |-> (pre_q == '0));

  assert_ap_closes_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (do_col && col_ap) |=> !open_q);

  assert_ref_closed_R9: assert property (@(posedge clk) disable iff (!rst_n)
    do_ref |-> (!open_q && act_q == '0));

endmodule

// File: rtl/dram_bank_sched.sv
module dram_bank_sched #(
  parameter int N_BANK     = 8,
  parameter int ROW_W      = 16,
  parameter int AP_BIT     = 10,
  parameter int BC_BIT     = 12,
  parameter int T_RCD      = 11,
  parameter int T_RP       = 11,
  parameter int T_RC       = 39,
  parameter int T_RAS      = 28,
  parameter int T_RFC      = 208,
  parameter int T_BL8      = 4,
  parameter int T_BL4      = 2,
  parameter int T_REFI     = 6240,
  parameter int T_REFI_HOT = 3120,
  localparam int BA_W      = $clog2(N_BANK)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             temp_hot,
  input  logic             req_valid,
  input  logic [2:0]       req_op,
  input  logic [BA_W-1:0]  req_bank,
  input  logic [ROW_W-1:0] req_addr,
  output logic             req_ready,
  output logic             req_err,
  output logic             refresh_due,
  output logic             cmd_valid,
  output logic [2:0]       cmd_op,
  output logic [BA_W-1:0]  cmd_bank,
  output logic [ROW_W-1:0] cmd_addr
);

  import dbs_pkg::*;

  localparam int T_MAX = imax(imax(imax(T_RCD, T_RC), imax(T_RAS, T_RFC)),
                              T_RP + imax(T_BL8, T_BL4));
  localparam int CW    = $clog2(T_MAX + 1);

  // reset: asserted asynchronously, released on a clock edge
  logic rst_m_q, rst_s_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m_q <= 1'b0;
      rst_s_q <= 1'b0;
    end else begin
      rst_m_q <= 1'b1;
      rst_s_q <= rst_m_q;
    end
  end

  logic [N_BANK-1:0] open_v, act_ok_v, col_ok_v, pre_ok_v;
  logic [N_BANK-1:0] do_act, do_col, do_pre;
  logic              any_open, all_act_ok;
  logic              drain_found;
  logic [BA_W-1:0]   drain_idx;
  logic              ref_due;

  logic              iss, err_d;
  logic [2:0]        iss_op;
  logic [BA_W-1:0]   iss_bank;
  logic [ROW_W-1:0]  iss_addr;
  logic              iss_ref;

  assign any_open   = |open_v;
  assign all_act_ok = &act_ok_v;
  assign iss_ref    = iss && (iss_op == OP_REF);

  generate
    for (genvar gi = 0; gi < N_BANK; gi++) begin : g_bank
      assign do_act[gi] = iss && (iss_op == OP_ACT) && (iss_bank == BA_W'(gi));
      assign do_col[gi] = iss && ((iss_op == OP_RD) || (iss_op == OP_WR)) &&
                          (iss_bank == BA_W'(gi));
      assign do_pre[gi] = iss && (iss_op == OP_PRE) && (iss_bank == BA_W'(gi));

      dbs_bank #(
        .CW(CW), .T_RCD(T_RCD), .T_RP(T_RP), .T_RC(T_RC), .T_RAS(T_RAS),
        .T_RFC(T_RFC), .T_BL8(T_BL8), .T_BL4(T_BL4)
      ) u_bank (
        .clk     (clk),
        .rst_n   (rst_s_q),
        .do_act  (do_act[gi]),
        .do_col  (do_col[gi]),
        .col_ap  (iss_addr[AP_BIT]),
        .col_bc  (iss_addr[BC_BIT]),
        .do_pre  (do_pre[gi]),
        .do_ref  (iss_ref),
        .is_open (open_v[gi]),
        .act_ok  (act_ok_v[gi]),
        .col_ok  (col_ok_v[gi]),
        .pre_ok  (pre_ok_v[gi])
      );
    end
  endgenerate

  dbs_pick #(.N(N_BANK), .IW(BA_W)) u_drain (
    .req   (open_v & pre_ok_v),
    .found (drain_found),
    .idx   (drain_idx)
  );

  dbs_refi #(.T_REFI(T_REFI), .T_REFI_HOT(T_REFI_HOT)) u_refi (
    .clk   (clk),
    .rst_n (rst_s_q),
    .hot   (temp_hot),
    .clr   (iss_ref),
    .due   (ref_due)
  );

  // command decision
  always_comb begin
    iss       = 1'b0;
    iss_op    = OP_NOP;
    iss_bank  = req_bank;
    iss_addr  = req_addr;
    req_ready = 1'b0;
    err_d     = 1'b0;
    if (ref_due) begin
      iss_addr = '0;
      if (!any_open) begin
        if (all_act_ok) begin
          iss    = 1'b1;
          iss_op = OP_REF;
        end
      end else if (drain_found) begin
        iss      = 1'b1;
        iss_op   = OP_PRE;
        iss_bank = drain_idx;
      end
    end else if (req_valid) begin
      case (req_op)
        OP_NOP: req_ready = 1'b1;
        OP_ACT: begin
          if (open_v[req_bank]) begin
            req_ready = 1'b1;
            err_d     = 1'b1;
          end else if (act_ok_v[req_bank]) begin
            req_ready = 1'b1;
            iss       = 1'b1;
            iss_op    = OP_ACT;
          end
        end
        OP_RD, OP_WR: begin
          if (!open_v[req_bank]) begin
            req_ready = 1'b1;
            err_d     = 1'b1;
          end else if (col_ok_v[req_bank]) begin
            req_ready = 1'b1;
            iss       = 1'b1;
            iss_op    = req_op;
          end
        end
        OP_PRE: begin
          if (pre_ok_v[req_bank]) begin
            req_ready = 1'b1;
            iss       = 1'b1;
            iss_op    = OP_PRE;
          end
        end
        OP_REF: begin
          if (any_open) begin
            req_ready = 1'b1;
            err_d     = 1'b1;
          end else if (all_act_ok) begin
            req_ready = 1'b1;
            iss       = 1'b1;
            iss_op    = OP_REF;
          end
        end
        default: begin
          req_ready = 1'b1;
          err_d     = 1'b1;
        end
      endcase
    end
  end

  // registered command bus
  logic             cmd_valid_q, err_q;
  logic [2:0]       cmd_op_q;
  logic [BA_W-1:0]  cmd_bank_q;
  logic [ROW_W-1:0] cmd_addr_q;

  always_ff @(posedge clk or negedge rst_s_q) begin
    if (!rst_s_q) begin
      cmd_valid_q <= 1'b0;
      err_q       <= 1'b0;
    end else begin
      cmd_valid_q <= iss;
      err_q       <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_s_q) begin
    if (!rst_s_q) begin
      cmd_op_q   <= OP_NOP;
      cmd_bank_q <= '0;
      cmd_addr_q <= '0;
    end else if (iss) begin
      cmd_op_q   <= iss_op;
      cmd_bank_q <= iss_bank;
      cmd_addr_q <= iss_addr;
    end
  end

  assign cmd_valid   = cmd_valid_q;
  assign cmd_op      = cmd_op_q;
  assign cmd_bank    = cmd_bank_q;
  assign cmd_addr    = cmd_addr_q;
  assign req_err     = err_q;
  assign refresh_due = ref_due;

  assert_due_blocks_R8: assert property (@(posedge clk) disable iff (!rst_s_q)
    ref_due |-> !req_ready);

  assert_ref_all_closed_R8: assert property (@(posedge clk) disable iff (!rst_s_q)
    iss_ref |-> !any_open);

  assert_one_bank_cmd_R1: assert property (@(posedge clk) disable iff (!rst_s_q)
    $onehot0(do_act | do_col | do_pre));

  assert_err_no_cmd_R6: assert property (@(posedge clk) disable iff (!rst_s_q)
    req_err |-> !cmd_valid);

endmodule

// File: tb/dram_bank_sched_bench.sv
`timescale 1ns/1ps
module dram_bank_sched_bench;

  localparam int TRCD = 11, TRP = 11, TRC = 39, TRAS = 28, TRFC = 40;
  localparam int REFI = 900, REFI_HOT = 450;
  localparam logic [2:0] C_NOP = 0, C_ACT = 1, C_RD = 2, C_WR = 3, C_PRE = 4, C_REF = 5;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        temp_hot;
  logic        req_valid;
  logic [2:0]  req_op;
  logic [2:0]  req_bank;
  logic [15:0] req_addr;
  logic        req_ready, req_err, refresh_due, cmd_valid;
  logic [2:0]  cmd_op;
  logic [2:0]  cmd_bank;
  logic [15:0] cmd_addr;

  always #10 clk = ~clk;

  dram_bank_sched #(.T_RFC(TRFC), .T_REFI(REFI), .T_REFI_HOT(REFI_HOT)) u_dram_bank_sched (
    .clk(clk), .rst_n(rst_n), .temp_hot(temp_hot), .req_valid(req_valid),
    .req_op(req_op), .req_bank(req_bank), .req_addr(req_addr),
    .req_ready(req_ready), .req_err(req_err), .refresh_due(refresh_due),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_bank(cmd_bank), .cmd_addr(cmd_addr)
  );

  int unsigned n_checks = 0, n_errors = 0;
  longint cyc = 0;
  longint last_act[8], close_t[8], last_rw[8], bl_rw[8], last_pre[8];
  bit     open_m[8];
  longint last_ref = -100000, due_start = 0, e_cnt = 0;
  bit     e_valid = 0, prev_due = 0;
  bit     exp_pend = 0, exp_err = 0;
  logic [2:0]  exp_op, exp_b;
  logic [15:0] exp_a;

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint expv);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, expv);
    end
  endtask

  function automatic bit pred_err(input logic [2:0] op, input logic [2:0] b);
    bit any = 0;
    for (int i = 0; i < 8; i++) any |= open_m[i];
    case (op)
      C_ACT:       return open_m[b];
      C_RD, C_WR:  return !open_m[b];
      C_REF:       return any;
      C_NOP, C_PRE: return 0;
      default:     return 1;
    endcase
  endfunction

  // timing scoreboard for one observed command
  task automatic score(input logic [2:0] op, input logic [2:0] b, input logic [15:0] a,
                       input bit internal);
    longint bl;
    case (op)
      C_ACT: begin
        chk(!open_m[b], "R6", "act to open bank", open_m[b], 0);
        chk(cyc - last_act[b] >= TRC, "R3", "act-act gap", cyc - last_act[b], TRC);
        chk(cyc - close_t[b] >= TRP, "R3", "close-act gap", cyc - close_t[b], TRP);
        chk(cyc - last_ref >= TRFC, "R9", "ref-act gap", cyc - last_ref, TRFC);
        open_m[b] = 1; last_act[b] = cyc;
      end
      C_RD, C_WR: begin
        bl = a[12] ? 2 : 4;
        chk(open_m[b], "R6", "column to closed bank", open_m[b], 1);
        chk(cyc - last_act[b] >= TRCD, "R2", "act-col gap", cyc - last_act[b], TRCD);
        if (a[10]) begin open_m[b] = 0; close_t[b] = cyc + bl; end
        last_rw[b] = cyc; bl_rw[b] = bl;
      end
      C_PRE: begin
        if (open_m[b])
          chk(cyc - last_act[b] >= TRAS, "R4", "act-pre gap", cyc - last_act[b], TRAS);
        chk(cyc - last_rw[b] >= bl_rw[b], "R4", "col-pre gap", cyc - last_rw[b], bl_rw[b]);
        if (open_m[b]) begin open_m[b] = 0; close_t[b] = cyc; end
        last_pre[b] = cyc;
      end
      C_REF: begin
        for (int i = 0; i < 8; i++) begin
          chk(!open_m[i], "R8", "bank open at refresh", open_m[i], 0);
          chk(cyc - close_t[i] >= TRP, "R3", "close-ref gap", cyc - close_t[i], TRP);
          chk(cyc - last_act[i] >= TRC, "R3", "act-ref gap", cyc - last_act[i], TRC);
        end
        chk(cyc - last_ref >= TRFC, "R9", "ref-ref gap", cyc - last_ref, TRFC);
        if (internal)
          chk(cyc - due_start <= TRC + TRP + 4, "R8", "drain time", cyc - due_start, TRC + TRP + 4);
        last_ref = cyc; e_cnt = 0; e_valid = 1;
      end
      default: chk(0, "R1", "bad opcode on bus", op, 0);
    endcase
  endtask

  task automatic tick();
    longint lim;
    @(negedge clk);
    cyc++;
    if (cyc % 4000 == 0) temp_hot = ~temp_hot;
    #1;
    if (exp_pend) begin
      if (exp_err) begin
        chk(req_err == 1'b1, "R6", "refused request flag", req_err, 1);
        chk(cmd_valid == 1'b0, "R6", "refused request issued", cmd_valid, 0);
      end else if (exp_op == C_NOP) begin
        chk(!req_err && !cmd_valid, "R11", "no-op effect", {req_err, cmd_valid}, 0);
      end else begin
        chk(cmd_valid && cmd_op == exp_op && cmd_bank == exp_b && cmd_addr == exp_a, "R1",
            "issued command", {cmd_valid, cmd_op, cmd_bank, cmd_addr},
            {1'b1, exp_op, exp_b, exp_a});
        chk(!req_err, "R6", "error on legal request", req_err, 0);
      end
    end else begin
      chk(!req_err, "R6", "spurious error", req_err, 0);
      if (cmd_valid)
        chk(prev_due && (cmd_op == C_PRE || cmd_op == C_REF), "R8", "unrequested command",
            {prev_due, cmd_op}, {1'b1, C_PRE});
    end
    if (cmd_valid) score(cmd_op, cmd_bank, cmd_addr, !exp_pend);
    exp_pend = 0;
    if (e_valid) begin
      if (!(cmd_valid && cmd_op == C_REF)) e_cnt++;
      lim = temp_hot ? REFI_HOT : REFI;
      chk(refresh_due == (e_cnt >= lim - 1), "R7", "refresh due level", refresh_due,
          e_cnt >= lim - 1);
    end
    if (refresh_due && !prev_due) due_start = cyc;
    prev_due = refresh_due;
  endtask

  task automatic idle(input int n);
    req_valid = 1'b0;
    repeat (n) tick();
  endtask

  task automatic send(input logic [2:0] op, input logic [2:0] b, input logic [15:0] a);
    int waited = 0;
    req_op = op; req_bank = b; req_addr = a; req_valid = 1'b1;
    forever begin
      #1;
      if (refresh_due) chk(!req_ready, "R8", "request taken while due", req_ready, 0);
      if (req_ready) begin
        exp_pend = 1; exp_err = pred_err(op, b);
        exp_op = op; exp_b = b; exp_a = a;
        tick();
        req_valid = 1'b0;
        break;
      end
      tick();
      waited++;
      if (waited > 3000) begin
        chk(0, "R8", "request never accepted", waited, 0);
        req_valid = 1'b0;
        break;
      end
    end
  endtask

  initial begin
    #3000000;
    chk(0, "R8", "watchdog expired", cyc, 150000);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    logic [2:0] op, b;
    logic [15:0] a;
    int r;
    longint t;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 8; i++) begin
      last_act[i] = -100000; close_t[i] = -100000; last_rw[i] = -100000;
      bl_rw[i] = 0; last_pre[i] = -100000; open_m[i] = 0;
    end
    rst_n = 1'b0; temp_hot = 1'b0; req_valid = 1'b0;
    req_op = 0; req_bank = 0; req_addr = 0;
    repeat (3) begin
      @(negedge clk);
      chk(!cmd_valid && !req_err && !refresh_due, "R10", "reset outputs",
          {cmd_valid, req_err, refresh_due}, 0);
    end
    rst_n = 1'b1;
    idle(4);
    chk(!cmd_valid && !req_err && !refresh_due, "R10", "after reset",
        {cmd_valid, req_err, refresh_due}, 0);

    // directed corner cases
    send(C_ACT, 0, 16'h1234);
    send(C_RD, 0, 16'h0005);
    idle(2);
    chk(last_rw[0] - last_act[0] == TRCD, "R2", "exact act-read gap", last_rw[0] - last_act[0], TRCD);
    send(C_ACT, 1, 16'h00AA);
    t = last_act[1];
    send(C_PRE, 1, 16'h0);
    idle(2);
    chk(last_pre[1] - t == TRAS, "R4", "exact act-pre gap", last_pre[1] - t, TRAS);
    send(C_ACT, 1, 16'h00BB);
    idle(2);
    chk(last_act[1] - last_pre[1] == TRP, "R3", "exact pre-act gap", last_act[1] - last_pre[1], TRP);
    chk(last_act[1] - t == TRC, "R3", "exact act-act gap", last_act[1] - t, TRC);
    send(C_ACT, 1, 16'h00CC);
    send(C_REF, 0, 16'h0);
    send(3'd7, 2, 16'h0);
    send(3'd6, 3, 16'h0);
    send(C_NOP, 0, 16'h0);
    send(C_RD, 2, 16'h0001);
    send(C_ACT, 2, 16'h0042);
    idle(TRC + 2);
    send(C_RD, 2, 16'h0403);
    send(C_RD, 2, 16'h0005);
    send(C_ACT, 2, 16'h0009);
    idle(2);
    chk(last_act[2] - last_rw[2] == 4 + TRP, "R5", "auto-close act gap", last_act[2] - last_rw[2], 4 + TRP);
    send(C_ACT, 3, 16'h0001);
    idle(TRC + 2);
    send(C_WR, 3, 16'h1401);
    send(C_ACT, 3, 16'h0002);
    idle(2);
    chk(last_act[3] - last_rw[3] == 2 + TRP, "R5", "chopped auto-close gap", last_act[3] - last_rw[3], 2 + TRP);
    for (int i = 0; i < 4; i++) send(C_PRE, 3'(i), 16'h0);
    send(C_REF, 0, 16'h0);
    send(C_ACT, 4, 16'h0007);
    idle(2);
    chk(last_act[4] - last_ref == TRFC, "R9", "exact ref-act gap", last_act[4] - last_ref, TRFC);

    // random traffic
    for (int k = 0; k < 2500; k++) begin
      b = 3'($urandom_range(0, 7));
      r = $urandom_range(0, 99);
      a = 16'($urandom());
      if (open_m[b]) begin
        if (r < 30) op = C_RD;
        else if (r < 60) op = C_WR;
        else if (r < 85) op = C_PRE;
        else if (r < 92) op = C_ACT;
        else if (r < 96) op = C_NOP;
        else op = C_REF;
      end else begin
        if (r < 75) op = C_ACT;
        else if (r < 82) op = C_RD;
        else if (r < 88) op = C_PRE;
        else if (r < 93) op = C_REF;
        else if (r < 97) op = C_NOP;
        else op = 3'd7;
      end
      if (op == C_RD || op == C_WR) begin
        a = {3'b000, ($urandom_range(0, 3) == 0), 1'b0, ($urandom_range(0, 3) == 0),
             10'($urandom())};
      end
      send(op, b, a);
      idle($urandom_range(0, 3));
    end
    idle(2 * REFI);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule